// File: doc/BRIEF.md
# Local-Bus Drive Timing Register Block

This block is the byte-wide register front end of a two-channel disk accelerator sitting on a processor local bus. A strap places its four-byte I/O window at one of two bases. Inside the window it keeps two read/write timing bytes and a control byte. A read-only identity and configuration byte is built from strap pins. Software uses the identity code and the exact readback of the timing bytes to detect the part. It then loads one timing byte per drive or per port.

At the drive side, the block selects the timing byte for the drive being accessed. With the single-port mode bit set, the drive number chooses between the two timing bytes. With it clear, the port number chooses. The block also brings out the port-mode, disk-only and buffering-enable bits of the control byte. Reads return data one clock after the read strobe, together with a hit flag. Addresses outside the window never raise that flag.

Top module: `vlb_timing_regs`

## Requirements
- R1: The window covers base..base+3, where base is 0x30 when `strap_win_hi` is 0 and 0xB0 when it is 1. Accesses at any other address neither write state nor raise `bus_rd_hit`.
- R2: Offset 0 holds timing byte A and offset 2 holds timing byte B. Each reads back exactly the last byte written to it.
- R3: Offset 1 reads as the configuration byte. Bit 0 is `strap_ide_pri`, bit 1 is `strap_win_hi`, bit 2 is `strap_slow_bus` and bit 3 is 1. Bits 7:4 are 1010 when `strap_id_alt` is 0 and 0101 when it is 1.
- R4: Writes to offset 1 change no register.
- R5: Offset 3 is the control byte. Bits 2 and 3 always read 1. All other bits read back as last written.
- R6: After reset, both timing bytes are 0x00 and the control byte is 0xDF.
- R7: A read strobe inside the window gives `bus_rd_hit`=1 and the register value on `bus_rdata` in the next cycle. Otherwise, in that cycle `bus_rd_hit`=0 and `bus_rdata`=0x00.
- R8: When control bit 0 is 1, `drive_sel` picks the timing byte (0 gives A, 1 gives B). When control bit 0 is 0, `port_sel` picks it the same way. `timing_idx` shows the choice (0 = A, 1 = B).
- R9: `single_port` follows control bit 0, `disks_only` follows control bit 1 and `buf_en` follows control bit 7. Writing 0x5F therefore clears `buf_en`.
- R10: `timing_out` shows a new value written to the selected timing byte in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_win_hi | input | 1 | Window base strap: 1 selects 0xB0, 0 selects 0x30 |
| strap_ide_pri | input | 1 | IDE base strap reported in config bit 0 |
| strap_slow_bus | input | 1 | Bus at or below 33 MHz, reported in config bit 2 |
| strap_id_alt | input | 1 | Picks the alternate identity nibble |
| bus_addr | input | 8 | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| bus_rd_hit | output | 1 | Read fell inside the window |
| drive_sel | input | 1 | Drive number within the current port |
| port_sel | input | 1 | Port (channel) number of the current access |
| timing_out | output | 8 | Timing byte for the current drive |
| timing_idx | output | 1 | Which timing byte is selected (0 = A, 1 = B) |
| single_port | output | 1 | Control bit 0: only the primary port is enabled |
| disks_only | output | 1 | Control bit 1: primary port carries disks only |
| buf_en | output | 1 | Control bit 7: read-ahead and post-write buffering enabled |

## Verification
The assertions assume `bus_wr` and `bus_rd` are never high in the same cycle. They also assume each strobe is a single-cycle pulse whose address and data are stable around the clock edge. The bench drives every access from one task that raises exactly one strobe for one cycle on the falling edge and drops it on the next falling edge. The straps are changed only while no strobe is active, so the configuration byte and the window base never move under an access in flight.

// File: rtl/vlbt_pkg.sv
package vlbt_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned OFS_W = 2;
  localparam int unsigned TMR_N = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_TMR_A = 2'd0,
    OFS_CFG   = 2'd1,
    OFS_TMR_B = 2'd2,
    OFS_CTRL  = 2'd3
  } reg_ofs_e;

  localparam logic [3:0] ID_PRI = 4'b1010;
  localparam logic [3:0] ID_ALT = 4'b0101;

  // control bit positions used by the drive-side outputs
  localparam int unsigned CB_SINGLE = 0;
  localparam int unsigned CB_DISKS  = 1;
  localparam int unsigned CB_BUF    = 7;

  function automatic logic [REG_W-1:0] build_cfg(
    input logic id_alt,
    input logic slow_bus,
    input logic win_hi,
    input logic ide_pri
  );
    logic [3:0] id;
    id = id_alt ? ID_ALT : ID_PRI;
    return {id, 1'b1, slow_bus, win_hi, ide_pri};
  endfunction

endpackage

// File: rtl/vlbt_decode.sv
module vlbt_decode
  import vlbt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_LO = 8'h30,
  parameter logic [ADDR_W-1:0] BASE_HI = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_ofs_e          ofs,
  output logic              rd_en,
  output logic [TMR_N-1:0]  tmr_we,
  output logic              ctrl_we
);

  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base;
  logic              hit;

  always_comb begin
    base    = win_hi ? BASE_HI : BASE_LO;
    hit     = (addr[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W]);
    ofs     = reg_ofs_e'(addr[OFS_W-1:0]);
    rd_en   = hit && rd;
    tmr_we  = '0;
    ctrl_we = 1'b0;
    if (hit && wr) begin
      unique case (ofs)
        OFS_TMR_A: tmr_we[0] = 1'b1;
        OFS_TMR_B: tmr_we[1] = 1'b1;
        OFS_CTRL:  ctrl_we   = 1'b1;
        default:   ;
      endcase
    end
  end

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_we, ctrl_we}));

  p_cfg_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ofs == OFS_CFG) |-> (tmr_we == '0 && !ctrl_we));

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = base[ADDR_W-1:OFS_W];

endmodule

// File: rtl/vlbt_timer_bank.sv
module vlbt_timer_bank #(
  parameter int unsigned NUM   = 2,
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] RESET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM-1:0]        we,
  input  logic [W-1:0]          wdata,
  output logic [NUM-1:0][W-1:0] q
);

  for (genvar k = 0; k < NUM; k++) begin : g_tmr
    logic [W-1:0] tmr_q, tmr_d;

    always_comb begin
      tmr_d = tmr_q;
      if (we[k]) tmr_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tmr_q <= RESET;
      else if (we[k]) tmr_q <= tmr_d;
    end

    assign q[k] = tmr_q;

    p_tmr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we[k] |=> (q[k] == $past(wdata)));

    p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we[k] |=> $stable(q[k]));
  end

endmodule

// File: rtl/vlbt_ctrl_reg.sv
module vlbt_ctrl_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RESET = 8'hDF,
  parameter logic [W-1:0] FORCE_ONES = 8'h0C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = wdata | FORCE_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= RESET | FORCE_ONES;
    else if (we) ctrl_q <= ctrl_d;
  end

  assign q = ctrl_q;

  p_ctrl_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & FORCE_ONES) == FORCE_ONES));

  p_ctrl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~FORCE_ONES) == ($past(wdata) & ~FORCE_ONES)));

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/vlbt_timing_sel.sv
module vlbt_timing_sel #(
  parameter int unsigned W = 8
) (
  input  logic         single_mode,
  input  logic         drive_sel,
  input  logic         port_sel,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  output logic         idx,
  output logic [W-1:0] timing
);

  always_comb begin
    idx    = single_mode ? drive_sel : port_sel;
    timing = idx ? tmr_b : tmr_a;
  end

endmodule

// File: rtl/vlb_timing_regs.sv
module vlb_timing_regs
  import vlbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_LO = 8'h30,
  parameter logic [ADDR_W-1:0] BASE_HI = 8'hB0,
  parameter logic [REG_W-1:0] TMR_RESET = 8'h00,
  parameter logic [REG_W-1:0] CTRL_RESET = 8'hDF,
  parameter logic [REG_W-1:0] CTRL_FORCE = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_win_hi,
  input  logic              strap_ide_pri,
  input  logic              strap_slow_bus,
  input  logic              strap_id_alt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rd_hit,
  input  logic              drive_sel,
  input  logic              port_sel,
  output logic [REG_W-1:0]  timing_out,
  output logic              timing_idx,
  output logic              single_port,
  output logic              disks_only,
  output logic              buf_en
);

  reg_ofs_e                    ofs;
  logic                        rd_en;
  logic [TMR_N-1:0]            tmr_we;
  logic                        ctrl_we;
  logic [TMR_N-1:0][REG_W-1:0] tmr_q;
  logic [REG_W-1:0]            ctrl_q;
  logic [REG_W-1:0]            cfg;

  vlbt_decode #(
    .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .win_hi(strap_win_hi),
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ofs(ofs), .rd_en(rd_en), .tmr_we(tmr_we), .ctrl_we(ctrl_we)
  );

  vlbt_timer_bank #(
    .NUM(TMR_N), .W(REG_W), .RESET(TMR_RESET)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .we(tmr_we), .wdata(bus_wdata), .q(tmr_q)
  );

  vlbt_ctrl_reg #(
    .W(REG_W), .RESET(CTRL_RESET), .FORCE_ONES(CTRL_FORCE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(bus_wdata), .q(ctrl_q)
  );

  vlbt_timing_sel #(.W(REG_W)) u_sel (
    .single_mode(ctrl_q[CB_SINGLE]), .drive_sel(drive_sel),
    .port_sel(port_sel), .tmr_a(tmr_q[0]), .tmr_b(tmr_q[1]),
    .idx(timing_idx), .timing(timing_out)
  );

  assign cfg         = build_cfg(strap_id_alt, strap_slow_bus, strap_win_hi, strap_ide_pri);
  assign single_port = ctrl_q[CB_SINGLE];
  assign disks_only  = ctrl_q[CB_DISKS];
  assign buf_en      = ctrl_q[CB_BUF];

  // read-return path
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             hit_q, hit_d;

  always_comb begin
    hit_d   = rd_en;
    rdata_d = '0;
    if (rd_en) begin
      unique case (ofs)
        OFS_TMR_A: rdata_d = tmr_q[0];
        OFS_CFG:   rdata_d = cfg;
        OFS_TMR_B: rdata_d = tmr_q[1];
        OFS_CTRL:  rdata_d = ctrl_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      hit_q   <= hit_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rd_hit = hit_q;

  p_hit_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_hit |-> $past(bus_rd));

  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_hit |-> (bus_rdata == '0));

  p_no_rd_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rd_hit);

  p_single_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    single_port |-> (timing_idx == drive_sel));

  p_dual_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !single_port |-> (timing_idx == port_sel));

  p_timing_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_we[0] && !ctrl_we && $stable(timing_idx) && timing_idx == 1'b0) |=>
      (timing_idx == 1'b1 || timing_out == $past(bus_wdata)));

endmodule

// File: tb/vlb_timing_regs_test.sv
module vlb_timing_regs_test;

  logic       clk, rst_n;
  logic       strap_win_hi, strap_ide_pri, strap_slow_bus, strap_id_alt;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, timing_out;
  logic       bus_wr, bus_rd, bus_rd_hit, drive_sel, port_sel;
  logic       timing_idx, single_port, disks_only, buf_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vlb_timing_regs uut (
    .clk(clk), .rst_n(rst_n),
    .strap_win_hi(strap_win_hi), .strap_ide_pri(strap_ide_pri),
    .strap_slow_bus(strap_slow_bus), .strap_id_alt(strap_id_alt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_hit(bus_rd_hit),
    .drive_sel(drive_sel), .port_sel(port_sel),
    .timing_out(timing_out), .timing_idx(timing_idx),
    .single_port(single_port), .disks_only(disks_only), .buf_en(buf_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; h = bus_rd_hit;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // vector: {req, op(1=wr,2=rd), addr, data, expected}
  localparam int NV = 18;
  localparam logic [39:0] VEC [NV] = '{
    {8'd2, 8'd1, 8'h30, 8'hA5, 8'h00},   // R2 timing A
    {8'd2, 8'd2, 8'h30, 8'h00, 8'hA5},
    {8'd2, 8'd1, 8'h32, 8'h3C, 8'h00},   // R2 timing B
    {8'd2, 8'd2, 8'h32, 8'h00, 8'h3C},
    {8'd2, 8'd2, 8'h30, 8'h00, 8'hA5},
    {8'd4, 8'd1, 8'h31, 8'h00, 8'h00},   // R4 config write ignored
    {8'd3, 8'd2, 8'h31, 8'h00, 8'hAD},   // R3 config layout
    {8'd4, 8'd2, 8'h30, 8'h00, 8'hA5},
    {8'd4, 8'd2, 8'h32, 8'h00, 8'h3C},
    {8'd5, 8'd1, 8'h33, 8'h00, 8'h00},   // R5 forced bits
    {8'd5, 8'd2, 8'h33, 8'h00, 8'h0C},
    {8'd5, 8'd1, 8'h33, 8'hF0, 8'h00},
    {8'd5, 8'd2, 8'h33, 8'h00, 8'hFC},
    {8'd9, 8'd1, 8'h33, 8'h5F, 8'h00},   // R9 buffering off
    {8'd9, 8'd2, 8'h33, 8'h00, 8'h5F},
    {8'd2, 8'd1, 8'h30, 8'h5A, 8'h00},
    {8'd2, 8'd2, 8'h30, 8'h00, 8'h5A},
    {8'd2, 8'd2, 8'h32, 8'h00, 8'h3C}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic h;
    bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
    drive_sel = 0; port_sel = 0;
    strap_win_hi = 0; strap_ide_pri = 1; strap_slow_bus = 1; strap_id_alt = 0;
    do_reset();

    // R6 reset state
    check("R6 single_port", single_port, 1);
    check("R6 disks_only", disks_only, 1);
    check("R6 buf_en", buf_en, 1);
    check("R6 timing_out", timing_out, 8'h00);
    check("R7 idle hit", bus_rd_hit, 0);
    rd(8'h30, d, h); check("R6 timer A", d, 8'h00);
    rd(8'h32, d, h); check("R6 timer B", d, 8'h00);
    rd(8'h33, d, h); check("R6 control", d, 8'hDF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:24] == 8'd1) wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][23:16], d, h);
        check($sformatf("R%0d vec%0d data", VEC[i][39:32], i), d, VEC[i][7:0]);
        check($sformatf("R7 vec%0d hit", i), h, 1);
      end
    end

    // R9 outputs after 0x5F
    check("R9 buf_en", buf_en, 0);
    check("R9 single_port", single_port, 1);
    check("R9 disks_only", disks_only, 1);

    // R8 single-port mode: drive picks
    wr(8'h30, 8'h11); wr(8'h32, 8'h22);
    drive_sel = 0; port_sel = 1; #1;
    check("R8 single drv0", timing_out, 8'h11); check("R8 idx drv0", timing_idx, 0);
    drive_sel = 1; port_sel = 0; #1;
    check("R8 single drv1", timing_out, 8'h22); check("R8 idx drv1", timing_idx, 1);

    // R8/R9 dual-port mode: port picks
    wr(8'h33, 8'h0C);
    check("R9 single_port clear", single_port, 0);
    check("R9 disks_only clear", disks_only, 0);
    drive_sel = 1; port_sel = 0; #1;
    check("R8 dual port0", timing_out, 8'h11);
    drive_sel = 0; port_sel = 1; #1;
    check("R8 dual port1", timing_out, 8'h22);

    // R10 selected timing byte updates one cycle after write
    wr(8'h32, 8'h77);
    check("R10 timing_out follows", timing_out, 8'h77);

    // R7 / R1 outside the window
    rd(8'h34, d, h); check("R7 miss hit", h, 0); check("R7 miss data", d, 0);
    rd(8'h2F, d, h); check("R7 miss low hit", h, 0);
    rd(8'hB2, d, h); check("R1 hi base unused", h, 0);
    wr(8'hB2, 8'h99);
    rd(8'h32, d, h); check("R1 stray write ignored", d, 8'h77);

    // R1 move window to high base
    strap_win_hi = 1;
    rd(8'hB2, d, h); check("R1 hi hit", h, 1); check("R1 hi data", d, 8'h77);
    rd(8'h32, d, h); check("R1 lo now unused", h, 0);
    wr(8'h30, 8'h44);
    rd(8'hB0, d, h); check("R1 lo write ignored", d, 8'h11);
    rd(8'hB1, d, h); check("R3 cfg hi", d, 8'hAF);
    strap_id_alt = 1; strap_slow_bus = 0; strap_ide_pri = 0;
    rd(8'hB1, d, h); check("R3 cfg alt", d, 8'h5A);

    // R6 second reset
    do_reset();
    rd(8'hB0, d, h); check("R6 re-reset A", d, 8'h00);
    rd(8'hB2, d, h); check("R6 re-reset B", d, 8'h00);
    rd(8'hB3, d, h); check("R6 re-reset ctrl", d, 8'hDF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule